// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host manage Ethernet PHYs over the two-wire clause 22 management interface. The host programs a clock divisor and an enable bit, then writes a command word holding a PHY address, a register address, an operation and a start flag. The block derives the management clock from the host clock and shifts one complete frame out on the data line. On a read it releases the line so the PHY can return 16 bits, then stores those bits for the host.

The host bus is a plain single-cycle register port. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The host learns that a frame is finished by polling the ready bit. The data pin is split into an output value, an output enable and an input, so a tristate pad can be placed outside the block. No streaming interface exists, so there is no back-pressure to manage: a command written while the engine is busy is dropped.

Top module: `mdio_master`

## Requirements
- R1: While enabled, `mdc` is a square wave with a period of 2*(1+div) host cycles, where div is CTRL bits [DIV_W-1:0] at bus address 0.
- R2: While the enable bit (CTRL bit 15) is 0, `mdc` stays low and a command with its start flag set does not start a frame, so ready stays 1.
- R3: Address 1 is CMD: phy [4:0], reg [9:5], op [11:10], start [12], ready [13]. Address 2 holds the write data in bits [15:0]. Address 3 holds the read data in bits [15:0]. Unused bits read as 0.
- R4: An accepted command drops ready in the next cycle, and ready returns to 1 after the frame. The start bit always reads 0. A command written while ready is 0 is ignored.
- R5: A write frame (op 01) goes out MSB first as 32 ones, then 01, op 01, phy, reg, turnaround 10, and the 16 write-data bits.
- R6: A read frame (op 10) drives 32 ones, 01, 10, phy and reg. It holds `mdio_oe` low for the turnaround and the 16 data bits, and samples `mdio_i` at each rising `mdc`. The result appears in read-data bits [15:0] with the upper bits 0. It changes only when a read completes.
- R7: `mdio_o` changes, and `mdio_oe` rises, only in the host cycle in which `mdc` falls.
- R8: After reset, ready is 1, CTRL reads 0, `mdc` is 0 and `mdio_oe` is 0.
- R9: A command whose op is neither 01 nor 10 starts no frame, even with the start flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
The hardest case to reach from the ports is a command that lands while a frame is still in flight. The stimulus starts a read and, before polling, writes a second command while ready is low. The monitor must then see exactly one frame, and that frame must carry the first command's fields and read data. A second hard case is the point where the line changes hands during a read. A bench PHY responder drives the line from the falling edge after the turnaround starts, and the monitor checks that the master's enable stays low for every bit from there on.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_W       = 32;
  localparam int PRE_BITS    = 32;
  localparam int FRAME_BITS  = 64;
  localparam int HDR_BITS    = 46;   // bits driven before the turnaround
  localparam int DATA_FIRST  = 48;   // index of first data bit
  localparam int IDX_W       = $clog2(FRAME_BITS + 1);

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_CMD   = 2'd1;
  localparam logic [1:0] A_WDATA = 2'd2;
  localparam logic [1:0] A_RDATA = 2'd3;

  localparam int EN_BIT    = 15;
  localparam int START_BIT = 12;
  localparam int READY_BIT = 13;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = en && (cnt == div);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  is_rd;
  logic [15:0]           rsh;
  logic [FRAME_BITS-1:0] frame_w;

  assign frame_w = {{PRE_BITS{1'b1}}, 2'b01,
                    cmd.rd ? OP_RD : OP_WR,
                    cmd.phy, cmd.regad,
                    cmd.rd ? 2'b11 : 2'b10,
                    cmd.rd ? 16'h0000 : cmd.wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
      sh      <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      rsh     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        is_rd <= cmd.rd;
        sh    <= frame_w;
      end
    end else begin
      if (fall_evt) begin
        if (idx == IDX_W'(FRAME_BITS)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
          if (is_rd) rd_data <= rsh;
        end else begin
          mdio_o  <= sh[FRAME_BITS-1];
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
          mdio_oe <= !(is_rd && (idx >= IDX_W'(HDR_BITS)));
          idx     <= idx + 1'b1;
        end
      end
      if (rise_evt && is_rd && (idx > IDX_W'(DATA_FIRST)))
        rsh <= {rsh[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             busy,
  input  logic [15:0]      rd_data,
  output logic             en,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output mdio_cmd_t        cmd
);
  logic [15:0] wdata_q;
  logic [4:0]  phy_q;
  logic [4:0]  reg_q;
  logic [1:0]  op_q;
  logic [1:0]  op_w;
  logic        op_ok;

  assign op_w  = bus_wdata[11:10];
  assign op_ok = (op_w == OP_RD) || (op_w == OP_WR);
  assign start = bus_we && (bus_addr == A_CMD) && bus_wdata[START_BIT]
                 && en && !busy && op_ok;

  assign cmd.rd    = (op_w == OP_RD);
  assign cmd.phy   = bus_wdata[4:0];
  assign cmd.regad = bus_wdata[9:5];
  assign cmd.wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      div     <= '0;
      wdata_q <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      op_q    <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL: begin
          div <= bus_wdata[DIV_W-1:0];
          en  <= bus_wdata[EN_BIT];
        end
        A_WDATA: wdata_q <= bus_wdata[15:0];
        A_CMD: if (start) begin
          phy_q <= cmd.phy;
          reg_q <= cmd.regad;
          op_q  <= op_w;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[DIV_W-1:0] = div;
        bus_rdata[EN_BIT]    = en;
      end
      A_CMD: begin
        bus_rdata[4:0]       = phy_q;
        bus_rdata[9:5]       = reg_q;
        bus_rdata[11:10]     = op_q;
        bus_rdata[READY_BIT] = !busy;
      end
      A_WDATA: bus_rdata[15:0] = wdata_q;
      default: bus_rdata[15:0] = rd_data;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic             ctrl_en;
  logic [DIV_W-1:0] ctrl_div;
  logic             start_w;
  mdio_cmd_t        cmd_w;
  logic             busy_w;
  logic             ready_w;
  logic [15:0]      rd_data_w;
  logic             rise_w;
  logic             fall_w;

  assign ready_w = !busy_w;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w),
    .rd_data(rd_data_w), .en(ctrl_en), .div(ctrl_div),
    .start(start_w), .cmd(cmd_w)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .div(ctrl_div),
    .mdc(mdc), .rise_evt(rise_w), .fall_evt(fall_w)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .cmd(cmd_w),
    .rise_evt(rise_w), .fall_evt(fall_w), .mdio_i(mdio_i),
    .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        ready,
  input logic [15:0] rd_data
);
  // R2
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  // R7
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  // R7
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $fell(mdc));

  // R4
  drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !ready);

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .ready(ready_w), .rd_data(rd_data_w)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  import mdio_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b0, phy_val = 1'b1;
  logic        line;

  assign line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int n_chk = 0, n_fail = 0, frames = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_fn(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 6'h25} ^ 16'h5A3C;
  endfunction

  typedef struct { bit rd; logic [4:0] phy; logic [4:0] rg; logic [15:0] data; } exp_t;
  exp_t q[$];

  // monitor + PHY responder
  logic [33:0] hist = '0;
  bit          in_fr = 0, oe_bad = 0;
  int          pos = 0;
  logic [29:0] fb = '0;

  always @(posedge mdc) begin
    if (!in_fr) begin
      hist = {hist[32:0], line};
      if (hist == 34'h3_FFFF_FFFD) begin in_fr = 1; pos = 0; oe_bad = 0; end
    end else begin
      fb[29-pos] = line;
      if (pos >= 12 && fb[29:28] == OP_RD && mdio_oe) oe_bad = 1;
      pos++;
      if (pos == 30) begin
        exp_t e;
        in_fr = 0; hist = '0; frames++;
        if (q.size() == 0) chk(0, "R4", "unexpected frame", frames, 0);
        else begin
          e = q.pop_front();
          chk(fb[29:28] == (e.rd ? OP_RD : OP_WR), e.rd ? "R6" : "R5", "opcode", fb[29:28], e.rd ? OP_RD : OP_WR);
          chk(fb[27:23] == e.phy, "R5", "phy field", fb[27:23], e.phy);
          chk(fb[22:18] == e.rg, "R5", "reg field", fb[22:18], e.rg);
          if (!e.rd) chk(fb[17:16] == 2'b10, "R5", "turnaround", fb[17:16], 2);
          else chk(!oe_bad, "R6", "line released", oe_bad, 0);
          chk(fb[15:0] == e.data, e.rd ? "R6" : "R5", "data bits", fb[15:0], e.data);
        end
      end
    end
  end

  always @(negedge mdc) begin
    if (in_fr && pos >= 13 && fb[29:28] == OP_RD) begin
      phy_drv = 1'b1;
      phy_val = (pos == 13) ? 1'b0 : phy_fn(fb[27:23], fb[22:18])[29-pos];
    end else begin
      phy_drv = 1'b0;
      phy_val = 1'b1;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      bus_rd(A_CMD, d);
      if (d[READY_BIT]) return;
    end
    chk(0, "R4", "ready timeout", 0, 1);
  endtask

  task automatic xfer(input bit rd, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] wd);
    exp_t e;
    logic [31:0] d;
    bus_wr(A_WDATA, {16'h0, wd});
    e.rd = rd; e.phy = p; e.rg = r; e.data = rd ? phy_fn(p, r) : wd;
    q.push_back(e);
    bus_wr(A_CMD, (32'd1 << START_BIT) | {20'd0, rd ? OP_RD : OP_WR, r, p});
    bus_rd(A_CMD, d);
    chk(d[READY_BIT] == 1'b0, "R4", "ready low after start", d[READY_BIT], 0);
    wait_ready();
    bus_rd(A_CMD, d);
    chk(d[START_BIT] == 1'b0 && d[9:0] == {r, p}, "R3", "cmd readback", d, {r, p});
    if (rd) begin
      bus_rd(A_RDATA, d);
      chk(d == {16'h0, phy_fn(p, r)}, "R6", "read data", d, phy_fn(p, r));
    end
  endtask

  task automatic meas(output int n);
    n = 0;
    do @(negedge clk); while (mdc);
    do @(negedge clk); while (!mdc);
    do begin @(negedge clk); n++; end while (mdc);
    do begin @(negedge clk); n++; end while (!mdc);
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, fr0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    bus_rd(A_CTRL, d); chk(d == 0, "R8", "ctrl after reset", d, 0);
    bus_rd(A_CMD, d);  chk(d == (32'd1 << READY_BIT), "R8", "cmd after reset", d, 32'd1 << READY_BIT);
    chk(mdc == 0 && mdio_oe == 0, "R8", "pins after reset", {mdc, mdio_oe}, 0);

    // R2 disabled: command ignored, clock idle
    bus_wr(A_CMD, (32'd1 << START_BIT) | {20'd0, OP_WR, 5'd2, 5'd1});
    bus_rd(A_CMD, d); chk(d[READY_BIT], "R2", "ready while disabled", d[READY_BIT], 1);
    n = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (mdc) n++; end
    chk(n == 0, "R2", "mdc idle while disabled", n, 0);

    // R1 divisor periods
    bus_wr(A_CTRL, (32'd1 << EN_BIT) | 32'd3); meas(n);
    chk(n == 8, "R1", "period div=3", n, 8);
    bus_wr(A_CTRL, 32'd0);
    bus_wr(A_CTRL, (32'd1 << EN_BIT) | 32'd0); meas(n);
    chk(n == 2, "R1", "period div=0", n, 2);
    bus_wr(A_CTRL, 32'd0);
    bus_wr(A_CTRL, (32'd1 << EN_BIT) | 32'd1); meas(n);
    chk(n == 4, "R1", "period div=1", n, 4);
    bus_rd(A_CTRL, d); chk(d == ((32'd1 << EN_BIT) | 32'd1), "R3", "ctrl readback", d, (32'd1 << EN_BIT) | 32'd1);
    repeat (300) @(negedge clk);
    chk(frames == 0, "R2", "no frame from disabled command", frames, 0);

    // R5 / R6 transfers
    xfer(0, 5'h11, 5'h03, 16'hBEEF);
    xfer(1, 5'h01, 5'h02, 16'h0);
    xfer(0, 5'h1F, 5'h1F, 16'h0001);
    xfer(1, 5'h00, 5'h1F, 16'h0);
    xfer(1, 5'h1E, 5'h00, 16'h0);

    // R4 command while busy is ignored
    fr0 = frames;
    begin
      exp_t e;
      e.rd = 1; e.phy = 5'h03; e.rg = 5'h04; e.data = phy_fn(5'h03, 5'h04);
      q.push_back(e);
      bus_wr(A_CMD, (32'd1 << START_BIT) | {20'd0, OP_RD, 5'h04, 5'h03});
      repeat (20) @(negedge clk);
      bus_wr(A_CMD, (32'd1 << START_BIT) | {20'd0, OP_WR, 5'h09, 5'h07});
      wait_ready();
      repeat (400) @(negedge clk);
      chk(frames == fr0 + 1, "R4", "one frame for busy overlap", frames, fr0 + 1);
      bus_rd(A_RDATA, d);
      chk(d == {16'h0, phy_fn(5'h03, 5'h04)}, "R4", "first command's data", d, phy_fn(5'h03, 5'h04));
    end

    // R9 invalid opcode ignored
    fr0 = frames;
    bus_wr(A_CMD, (32'd1 << START_BIT) | {20'd0, 2'b11, 5'h05, 5'h05});
    bus_rd(A_CMD, d); chk(d[READY_BIT], "R9", "ready after bad op", d[READY_BIT], 1);
    repeat (400) @(negedge clk);
    chk(frames == fr0, "R9", "no frame for bad op", frames, fr0);

    // R6 read data held across a write
    xfer(0, 5'h02, 5'h02, 16'h1234);
    bus_rd(A_RDATA, d);
    chk(d == {16'h0, phy_fn(5'h03, 5'h04)}, "R6", "read data held", d, phy_fn(5'h03, 5'h04));

    repeat (50) @(negedge clk);
    chk(q.size() == 0, "R5", "all frames seen", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule